// File: doc/BRIEF.md
# CPU Power-Domain Shutdown Sequencer

This block turns off up to three secondary CPU power domains without software stepping through each control bit. Software first unlocks the control path by writing a 16-bit key and an enable bit through a simple write port. It then pulses `start`. From there the sequencer walks each domain through the same fixed list of control-bit changes and handshakes, one domain at a time. It raises `done` when the last domain reports that it is off.

Each domain has a 7-bit control word and an L1 memory power-down request line. The sequencer changes exactly one of these bits per clock. It halts at two points in each domain. The first is the L1 acknowledge. The second is the moment when both power-status vectors show the domain's bit cleared. Each halt is bounded by a programmable cycle limit. If the limit runs out, a sticky timeout flag is set, the number of the stalled domain is recorded, and the sequencer returns to idle.

Top module: `pd_shutdown_seq`

## Requirements
- R1: After reset, every control word reads 7'h4D, which means reset deasserted, both power switches on, isolation off, clock enabled and SRAM isolation deasserted. All L1 requests are 0, and `busy`, `done`, `ctrl_en` and `to_err` are all 0.
- R2: `ctrl_en` changes only on a write whose bits [31:16] equal the key parameter (default 16'hB16A), and it takes the value of bit 0 of that write. A write with any other key is ignored. A `start` is ignored while `ctrl_en` is 0.
- R3: Control-word bit encoding: bit 0 is reset (active low), bit 1 is isolation, bit 2 is the primary switch, bit 3 is the secondary switch, bit 4 is clock disable, bit 5 is SRAM clock isolation, and bit 6 is SRAM isolation (active low). The first steps for a domain are: set bit 1, then set bit 5, then clear bit 6, then raise its L1 request. The first of these changes appears on the second clock edge after `start` is sampled.
- R4: After raising the L1 request, the sequencer changes nothing further for that domain until its `l1_ack` bit is 1.
- R5: After the acknowledge, the sequencer clears bit 0, then sets bit 4, then clears bit 2, then clears bit 3.
- R6: The sequencer leaves a domain only when that domain's bit reads 0 in both `pwr_sta` and `pwr_sta_2nd`. Domain k (k = 0, 1, 2) uses bit 10+k of each vector, and the other bits are ignored.
- R7: Domains are handled strictly in the order 0, 1, 2. No bit of a domain changes until the previous domain has finished.
- R8: `done` is a single-cycle pulse one cycle after the last domain's two status bits are both seen clear. `busy` is 0 during that cycle and afterwards.
- R9: A `start` that arrives while a sequence is running has no effect.
- R10: If a wait lasts longer than `wait_limit`+1 cycles, `to_err` is set and `to_dom` is set to the domain index plus 1. The sequencer then returns to idle, and `to_err` stays set until reset. A wait that completes within the limit sets no error.
- R11: At most one bit across all control words and L1 requests changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control-enable word |
| reg_wdata | input | 32 | Write data: key in [31:16], enable in [0] |
| start | input | 1 | Pulse that begins a shutdown sequence |
| wait_limit | input | 16 | Cycle limit for each handshake wait |
| l1_ack | input | 3 | L1 power-down acknowledge, one bit per domain |
| pwr_sta | input | 16 | Primary power-status vector |
| pwr_sta_2nd | input | 16 | Secondary power-status vector |
| ctrl_word | output | 21 | Control words, domain k in bits [7k+6:7k] |
| l1_pdn_req | output | 3 | L1 power-down request, one bit per domain |
| ctrl_en | output | 1 | Control access unlocked |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| to_err | output | 1 | Sticky timeout flag |
| to_dom | output | 2 | Index plus 1 of the domain that timed out |

## Verification
The embedded assertions check the following on every clock: at most one control bit moves per cycle, the L1 request never rises before isolation is in place, reset falls only after an acknowledge, the secondary switch opens only after the primary switch and the clock disable, the enable changes only on a write, and the timeout flag stays set. What the assertions cannot show is the full cross-domain order of all 24 changes, the exact cycle of the first change, and the stall that holds while a handshake is late. Also beyond them are the single `done` pulse despite a repeated `start`, and how a restart behaves after a timeout. The directed scenarios cover these, using a bench model of the acknowledge and status responses with adjustable delays.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
    localparam int CW_W        = 7;
    localparam int B_RST_N     = 0;
    localparam int B_ISO       = 1;
    localparam int B_PON       = 2;
    localparam int B_PON2      = 3;
    localparam int B_CKDIS     = 4;
    localparam int B_SRAM_CKISO = 5;
    localparam int B_SRAM_ISO_N = 6;
    localparam logic [CW_W-1:0] CW_RESET = 7'h4D;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ISO, ST_CKISO, ST_SRAMISO, ST_L1REQ, ST_WACK,
        ST_RST, ST_CKDIS, ST_PON, ST_PON2, ST_WSTA, ST_FIN
    } seq_st_e;
endpackage

// File: rtl/pd_key_gate.sv
module pd_key_gate #(
    parameter int DATA_W = 32,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0] KEY = 16'hB16A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              en
);
    logic en_d, en_q;
    logic wdata_unused;

    assign wdata_unused = ^wdata;

    always_comb begin
        en_d = en_q;
        if (we && (wdata[DATA_W-1 -: KEY_W] == KEY))
            en_d = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    // R2: the enable moves only in response to a write
    p_en_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(we));
endmodule

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expired
);
    logic [LIMIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)               cnt_d = '0;
        else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);

    // R10: the count restarts from zero whenever it is cleared
    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import pd_seq_pkg::*;
#(
    parameter int N_DOM = 3,
    localparam int DW   = $clog2(N_DOM + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       ctrl_en,
    input  logic [N_DOM-1:0]           l1_ack,
    input  logic [N_DOM-1:0]           sta_clr,
    input  logic                       expired,
    output logic                       tmr_clr,
    output logic [N_DOM-1:0][CW_W-1:0] ctrl,
    output logic [N_DOM-1:0]           l1_req,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [DW-1:0]              err_dom
);
    typedef struct packed {
        seq_st_e                    st;
        logic [DW-1:0]              dom;
        logic [N_DOM-1:0][CW_W-1:0] ctrl;
        logic [N_DOM-1:0]           l1;
        logic                       err;
        logic [DW-1:0]              err_dom;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b1;
        unique case (r_q.st)
            ST_IDLE: if (start && ctrl_en) begin
                r_d.st  = ST_ISO;
                r_d.dom = '0;
            end
            ST_ISO: begin
                r_d.ctrl[r_q.dom][B_ISO] = 1'b1;
                r_d.st = ST_CKISO;
            end
            ST_CKISO: begin
                r_d.ctrl[r_q.dom][B_SRAM_CKISO] = 1'b1;
                r_d.st = ST_SRAMISO;
            end
            ST_SRAMISO: begin
                r_d.ctrl[r_q.dom][B_SRAM_ISO_N] = 1'b0;
                r_d.st = ST_L1REQ;
            end
            ST_L1REQ: begin
                r_d.l1[r_q.dom] = 1'b1;
                r_d.st = ST_WACK;
            end
            ST_WACK: begin
                tmr_clr = 1'b0;
                if (l1_ack[r_q.dom]) begin
                    r_d.st = ST_RST;
                end else if (expired) begin
                    r_d.err     = 1'b1;
                    r_d.err_dom = r_q.dom + DW'(1);
                    r_d.st      = ST_IDLE;
                end
            end
            ST_RST: begin
                r_d.ctrl[r_q.dom][B_RST_N] = 1'b0;
                r_d.st = ST_CKDIS;
            end
            ST_CKDIS: begin
                r_d.ctrl[r_q.dom][B_CKDIS] = 1'b1;
                r_d.st = ST_PON;
            end
            ST_PON: begin
                r_d.ctrl[r_q.dom][B_PON] = 1'b0;
                r_d.st = ST_PON2;
            end
            ST_PON2: begin
                r_d.ctrl[r_q.dom][B_PON2] = 1'b0;
                r_d.st = ST_WSTA;
            end
            ST_WSTA: begin
                tmr_clr = 1'b0;
                if (sta_clr[r_q.dom]) begin
                    if (r_q.dom == DW'(N_DOM - 1)) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.dom = r_q.dom + DW'(1);
                        r_d.st  = ST_ISO;
                    end
                end else if (expired) begin
                    r_d.err     = 1'b1;
                    r_d.err_dom = r_q.dom + DW'(1);
                    r_d.st      = ST_IDLE;
                end
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.dom     <= '0;
            r_q.ctrl    <= {N_DOM{CW_RESET}};
            r_q.l1      <= '0;
            r_q.err     <= 1'b0;
            r_q.err_dom <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl    = r_q.ctrl;
    assign l1_req  = r_q.l1;
    assign busy    = (r_q.st != ST_IDLE) && (r_q.st != ST_FIN);
    assign done    = (r_q.st == ST_FIN);
    assign err     = r_q.err;
    assign err_dom = r_q.err_dom;

    // R11: a single control bit moves per cycle
    p_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({r_q.ctrl, r_q.l1} ^ $past({r_q.ctrl, r_q.l1})) <= 1);

    // R2: no sequence leaves idle while control access is locked
    p_locked_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) && !ctrl_en |=> (r_q.st == ST_IDLE));

    // R10: the timeout flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    // R8: completion follows a cleared last-domain status
    p_done_after_sta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sta_clr[N_DOM-1]));

    for (genvar i = 0; i < N_DOM; i++) begin : g_dom_chk
        // R3: memory power-down is requested only once isolated
        p_l1_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.l1[i]) |-> (r_q.ctrl[i][B_ISO] && r_q.ctrl[i][B_SRAM_CKISO]
                                  && !r_q.ctrl[i][B_SRAM_ISO_N]));
        // R4: reset is pulled only after an acknowledge
        p_rst_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(r_q.ctrl[i][B_RST_N]) |-> (r_q.l1[i] && $past(l1_ack[i], 2)));
        // R5: the secondary switch opens last
        p_pon2_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(r_q.ctrl[i][B_PON2]) |-> (!r_q.ctrl[i][B_PON] && r_q.ctrl[i][B_CKDIS]
                                            && !r_q.ctrl[i][B_RST_N]));
    end
endmodule

// File: rtl/pd_shutdown_seq.sv
module pd_shutdown_seq
    import pd_seq_pkg::*;
#(
    parameter int N_DOM    = 3,
    parameter int DATA_W   = 32,
    parameter int KEY_W    = 16,
    parameter logic [KEY_W-1:0] KEY = 16'hB16A,
    parameter int LIMIT_W  = 16,
    parameter int STA_W    = 16,
    parameter int STA_BASE = 10,
    localparam int DW      = $clog2(N_DOM + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  start,
    input  logic [LIMIT_W-1:0]    wait_limit,
    input  logic [N_DOM-1:0]      l1_ack,
    input  logic [STA_W-1:0]      pwr_sta,
    input  logic [STA_W-1:0]      pwr_sta_2nd,
    output logic [N_DOM*CW_W-1:0] ctrl_word,
    output logic [N_DOM-1:0]      l1_pdn_req,
    output logic                  ctrl_en,
    output logic                  busy,
    output logic                  done,
    output logic                  to_err,
    output logic [DW-1:0]         to_dom
);
    logic [N_DOM-1:0]           sta_clr;
    logic [N_DOM-1:0][CW_W-1:0] ctrl;
    logic                       tmr_clr, expired;
    logic                       sta_unused;

    assign sta_unused = ^{pwr_sta, pwr_sta_2nd};

    for (genvar i = 0; i < N_DOM; i++) begin : g_sta
        assign sta_clr[i] = !pwr_sta[STA_BASE+i] && !pwr_sta_2nd[STA_BASE+i];
    end

    pd_key_gate #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_key (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .en(ctrl_en)
    );

    pd_wait_timer #(.LIMIT_W(LIMIT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(wait_limit), .expired(expired)
    );

    pd_seq_fsm #(.N_DOM(N_DOM)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_en(ctrl_en),
        .l1_ack(l1_ack), .sta_clr(sta_clr), .expired(expired), .tmr_clr(tmr_clr),
        .ctrl(ctrl), .l1_req(l1_pdn_req), .busy(busy), .done(done),
        .err(to_err), .err_dom(to_dom)
    );

    assign ctrl_word = ctrl;
endmodule

// File: tb/pd_shutdown_seq_test.sv
`timescale 1ns/1ps
module pd_shutdown_seq_test;
    localparam logic [15:0] KEY = 16'hB16A;
    localparam logic [6:0] W_ON   = 7'h4D;
    localparam logic [6:0] W_OFF  = 7'h32;
    localparam logic [6:0] W_PART = 7'h2F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic start = 1'b0;
    logic [15:0] wait_limit = 16'd200;
    logic [2:0] l1_ack;
    logic [15:0] pwr_sta, pwr_sta_2nd;
    logic [20:0] ctrl_word;
    logic [2:0] l1_pdn_req;
    logic ctrl_en, busy, done, to_err;
    logic [1:0] to_dom;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // plant model
    int ack_dly = 3, sta_dly = 2;
    logic [2:0] ack_block = '0;
    logic hold_sta2 = 1'b0;
    logic [2:0] ack_r, sta_r, sta2_r;
    int ack_cnt[3], sc[3], s2c[3];

    always #2 clk = ~clk;

    assign l1_ack      = ack_r;
    assign pwr_sta     = {3'b101, sta_r, 10'h2B5};
    assign pwr_sta_2nd = {3'b110, sta2_r, 10'h16A};

    pd_shutdown_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .start(start), .wait_limit(wait_limit), .l1_ack(l1_ack),
        .pwr_sta(pwr_sta), .pwr_sta_2nd(pwr_sta_2nd), .ctrl_word(ctrl_word),
        .l1_pdn_req(l1_pdn_req), .ctrl_en(ctrl_en), .busy(busy), .done(done),
        .to_err(to_err), .to_dom(to_dom)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= '0; sta_r <= '1; sta2_r <= '1;
            for (int i = 0; i < 3; i++) begin ack_cnt[i] <= 0; sc[i] <= 0; s2c[i] <= 0; end
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (l1_pdn_req[i] && !ack_block[i]) begin
                    if (ack_cnt[i] < ack_dly) ack_cnt[i] <= ack_cnt[i] + 1;
                    else ack_r[i] <= 1'b1;
                end else begin
                    ack_cnt[i] <= 0; ack_r[i] <= 1'b0;
                end
                if (ctrl_word[i*7+2]) begin sc[i] <= 0; sta_r[i] <= 1'b1; end
                else if (sc[i] < sta_dly) sc[i] <= sc[i] + 1;
                else sta_r[i] <= 1'b0;
                if (ctrl_word[i*7+3] || hold_sta2) begin s2c[i] <= 0; sta2_r[i] <= 1'b1; end
                else if (s2c[i] < sta_dly) s2c[i] <= s2c[i] + 1;
                else sta2_r[i] <= 1'b0;
            end
        end
    end

    // change monitor
    int ev[64];
    int n_ev = 0, n_multi = 0, n_done = 0, ncnt = 0, clr_at = -1, done_at = -1;
    logic [23:0] prev_v;
    always @(negedge clk) begin
        logic [23:0] cur, dif;
        int c;
        cur = {l1_pdn_req, ctrl_word};
        ncnt++;
        if (rst_n) begin
            dif = cur ^ prev_v;
            c = $countones(dif);
            if (c > 1) n_multi++;
            for (int b = 0; b < 24; b++)
                if (dif[b] && n_ev < 64) begin
                    ev[n_ev] = (b < 21) ? ((b / 7) * 8 + (b % 7)) : ((b - 21) * 8 + 7);
                    n_ev++;
                end
            if (done) begin n_done++; if (done_at < 0) done_at = ncnt; end
            if (busy && !pwr_sta[12] && !pwr_sta_2nd[12] && clr_at < 0) clr_at = ncnt;
        end
        prev_v = cur;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_ev = 0; n_multi = 0; n_done = 0; clr_at = -1; done_at = -1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; reg_we = 1'b0; ack_block = '0; hold_sta2 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_log();
    endtask

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(ctrl_word == {3{W_ON}}, "R1 words", ctrl_word, {3{W_ON}});
        chk(l1_pdn_req == 3'b000, "R1 l1 req", l1_pdn_req, 0);
        chk({busy, done, ctrl_en, to_err} == 4'b0, "R1 flags", {busy, done, ctrl_en, to_err}, 0);
    endtask

    task automatic t_key();
        do_reset();
        pulse_start();
        @(negedge clk);
        chk(!busy && ctrl_word == {3{W_ON}}, "R2 locked start", busy, 0);
        write_reg({16'h1234, 16'h0001});
        chk(!ctrl_en, "R2 wrong key", ctrl_en, 0);
        pulse_start();
        @(negedge clk);
        chk(!busy, "R2 start after wrong key", busy, 0);
        write_reg({KEY, 16'h0001});
        chk(ctrl_en, "R2 right key", ctrl_en, 1);
        write_reg({KEY, 16'h0000});
        chk(!ctrl_en, "R2 key clears", ctrl_en, 0);
    endtask

    task automatic t_full_run();
        int exp_b[8] = '{1, 5, 6, 7, 0, 4, 2, 3};
        int bad = 0;
        do_reset();
        ack_dly = 3; sta_dly = 2; wait_limit = 16'd50;
        write_reg({KEY, 16'h0001});
        clear_log();
        pulse_start();
        chk(busy && ctrl_word[1] == 1'b0, "R3 no change yet", ctrl_word[1], 0);
        @(negedge clk);
        chk(ctrl_word[1] && !ctrl_word[5], "R3 first step timing", ctrl_word[6:0], 7'h4F);
        repeat (4) @(negedge clk);
        pulse_start();   // R9 extra start while busy
        wait_idle();
        chk(n_ev == 24, "R7 event count", n_ev, 24);
        for (int k = 0; k < 24 && k < n_ev; k++)
            if (ev[k] != (k / 8) * 8 + exp_b[k % 8]) bad++;
        chk(bad == 0, "R3 R5 R7 step order", bad, 0);
        chk(n_multi == 0, "R11 single change", n_multi, 0);
        chk(n_done == 1, "R9 one done pulse", n_done, 1);
        chk(done_at - clr_at == 1, "R8 done lag", done_at - clr_at, 1);
        chk(ctrl_word == {3{W_OFF}} && l1_pdn_req == 3'b111, "R5 final words", ctrl_word, {3{W_OFF}});
        chk(!busy && !to_err, "R8 idle after", {busy, to_err}, 0);
    endtask

    task automatic t_ack_wait();
        do_reset();
        ack_dly = 15; sta_dly = 2; wait_limit = 16'd100;
        write_reg({KEY, 16'h0001});
        pulse_start();
        for (int k = 0; k < 50 && !l1_pdn_req[0]; k++) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(busy && ctrl_word[0] && ctrl_word[2], "R4 held for ack", ctrl_word[6:0], 7'h2F);
        wait_idle();
        chk(!to_err && ctrl_word == {3{W_OFF}}, "R10 no error within limit", to_err, 0);
    endtask

    task automatic t_sta_wait();
        do_reset();
        ack_dly = 2; sta_dly = 1; wait_limit = 16'd300; hold_sta2 = 1'b1;
        write_reg({KEY, 16'h0001});
        pulse_start();
        repeat (40) @(negedge clk);
        chk(ctrl_word[6:0] == W_OFF && ctrl_word[13:7] == W_ON && busy,
            "R6 waits for second status", ctrl_word[13:7], W_ON);
        hold_sta2 = 1'b0;
        wait_idle();
        chk(ctrl_word == {3{W_OFF}}, "R6 proceeds after status", ctrl_word, {3{W_OFF}});
    endtask

    task automatic t_timeout();
        do_reset();
        ack_dly = 2; sta_dly = 1; wait_limit = 16'd4; ack_block = 3'b010;
        write_reg({KEY, 16'h0001});
        pulse_start();
        wait_idle();
        chk(to_err && to_dom == 2'd2, "R10 flag and domain", {to_err, to_dom}, 3'b110);
        chk(ctrl_word == {W_ON, W_PART, W_OFF} && !busy, "R10 abort state",
            ctrl_word, {W_ON, W_PART, W_OFF});
        ack_block = '0;
        pulse_start();
        wait_idle();
        chk(ctrl_word == {3{W_OFF}}, "R10 restart completes", ctrl_word, {3{W_OFF}});
        chk(to_err && to_dom == 2'd2, "R10 sticky", {to_err, to_dom}, 3'b110);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_key();
        t_full_run();
        t_ack_wait();
        t_sta_wait();
        t_timeout();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule